// File: doc/BRIEF.md
# Truncated Gold Ranging Code Generator

This block produces a satellite ranging code one chip at a time. Two 11-stage linear feedback shift registers step together on each chip-enable strobe. The output chip is the XOR of the first register's last stage with a phase-selected combination of the second register's stages. The per-satellite phase-select mask decides which stages of the second register take part, so one generator can produce any satellite's code.

The natural period of such a pair is 2047 chips. Here the period is cut to 2046 chips: after the 2046th chip both registers are reloaded with their seed and the chip index returns to zero. At a chip rate of one fifth of a 10.23 MHz reference, one period then lasts exactly 1 ms. A one-cycle epoch pulse marks the enable cycle of the last chip in each period, so downstream integrators can align to the millisecond.

A small state machine tracks where the generator is in its period. It has two states. PH_RUN covers chips 0 to 2044. PH_LAST covers chip 2045. The transition RUN_TO_LAST is taken on an enable while the index is 2044. The transition LAST_TO_RUN (the wrap) is taken on an enable while in PH_LAST, and that enable also reloads both registers. Synchronous reset forces PH_RUN.

Top module: `trunc_gold_gen`

## Requirements
- R1: While `rst` is high at a clock edge, that edge loads both registers with the seed and sets `chip_idx` to 0. The seed is stage 1 to stage 11 = 0,1,0,1,0,1,0,1,0,1,0.
- R2: The first register shifts stage k into stage k+1 on each enable. Its new stage 1 is the XOR of stages 1, 7, 8, 9, 10 and 11. With `phase_sel` = 0, `chip` equals stage 11 of the first register.
- R3: The second register shifts the same way. Its new stage 1 is the XOR of stages 1, 2, 3, 4, 5, 8, 9 and 11. Bit i of `phase_sel` selects stage i+1 of this register. `chip` is the first register's stage 11 XOR the parity of the selected stages, and it follows `phase_sel` combinationally.
- R4: Each cycle with `chip_en` high and `chip_idx` below 2045 increments `chip_idx` by one. `chip_idx` never exceeds 2045.
- R5: With `chip_en` low, `chip_idx` and both registers hold, so `chip` holds while `phase_sel` is unchanged.
- R6: An enable at `chip_idx` 2045 returns `chip_idx` to 0 and reloads both registers with the seed. The code therefore repeats every 2046 chips.
- R7: `epoch` is high exactly in the cycles where `chip_en` is high and `chip_idx` is 2045, and low in every other cycle.
- R8: A reset in the middle of a period restarts the code from chip 0 with the seed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Advance strobe, one chip per high cycle |
| phase_sel | input | 11 | Stage-select mask for the second register (bit i = stage i+1) |
| chip | output | 1 | Current code chip |
| chip_idx | output | 11 | Index of the current chip, 0 to 2045 |
| epoch | output | 1 | High in the enable cycle of the last chip of a period |

## Verification
`chip` and `chip_idx` come straight from registers that change at the clock edge where `chip_en` is high. They are due in the cycle that follows that edge. `chip` also responds at once to a change of `phase_sel`. `epoch` is combinational on the current index and `chip_en`, so it is due in the same cycle as the strobe.

The bench drives each input just after a falling edge and samples one time unit later, before the next rising edge. It compares the outputs with a stage-by-stage model that advances only after the sample of a cycle in which it drove an enable. Sweeps cover full periods across the wrap under three masks, idle gaps between strobes, and a reset in the middle of a period.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    localparam int unsigned LFSR_W   = 11;
    localparam int unsigned CODE_LEN = 2046;
    // bit i stands for stage i+1; a set bit feeds that stage back
    localparam logic [LFSR_W-1:0] PRI_POLY = 11'b111_1100_0001;
    localparam logic [LFSR_W-1:0] SEC_POLY = 11'b101_1001_1111;
    localparam logic [LFSR_W-1:0] SEED     = 11'b010_1010_1010;

    typedef enum logic [0:0] {
        PH_RUN  = 1'b0,
        PH_LAST = 1'b1
    } period_phase_t;
endpackage

// File: rtl/rcg_lfsr.sv
module rcg_lfsr #(
    parameter int unsigned       W    = 11,
    parameter logic [W-1:0]      POLY = '0,
    parameter logic [W-1:0]      INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         reload,
    output logic [W-1:0] state
);
    logic fb;

    always_comb begin
        fb = ^(state & POLY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= INIT;
        end else if (adv) begin
            if (reload) begin
                state <= INIT;
            end else begin
                state <= {state[W-2:0], fb};
            end
        end
    end
endmodule

// File: rtl/rcg_period_fsm.sv
module rcg_period_fsm
    import rcg_pkg::*;
#(
    parameter int unsigned LEN   = 2046,
    parameter int unsigned CNT_W = $clog2(LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [CNT_W-1:0] idx,
    output logic             wrap,
    output logic             epoch
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LEN - 1);
    localparam logic [CNT_W-1:0] PRE_IDX  = CNT_W'(LEN - 2);

    period_phase_t phase_q, phase_d;

    // next-state decision
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_RUN:  if (adv && idx == PRE_IDX) phase_d = PH_LAST;
            PH_LAST: if (adv)                   phase_d = PH_RUN;
            default:                            phase_d = PH_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RUN;
        end else begin
            phase_q <= phase_d;
        end
    end

    // outputs
    always_comb begin
        wrap  = 1'b0;
        epoch = 1'b0;
        unique case (phase_q)
            PH_RUN:  begin wrap = 1'b0; epoch = 1'b0; end
            PH_LAST: begin wrap = adv;  epoch = adv;  end
            default: begin wrap = 1'b0; epoch = 1'b0; end
        endcase
    end

    // chip counter
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (adv) begin
            idx <= wrap ? '0 : idx + 1'b1;
        end
    end

    logic unused_last;
    assign unused_last = ^LAST_IDX;
endmodule

// File: rtl/trunc_gold_gen.sv
module trunc_gold_gen
    import rcg_pkg::*;
#(
    parameter int unsigned W        = LFSR_W,
    parameter int unsigned PERIOD   = CODE_LEN,
    parameter logic [W-1:0] POLY_A  = PRI_POLY,
    parameter logic [W-1:0] POLY_B  = SEC_POLY,
    parameter logic [W-1:0] SEED_AB = SEED
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         chip_en,
    input  logic [W-1:0]                 phase_sel,
    output logic                         chip,
    output logic [$clog2(PERIOD)-1:0]    chip_idx,
    output logic                         epoch
);
    localparam int unsigned CNT_W = $clog2(PERIOD);
    localparam int unsigned NREG  = 2;
    localparam logic [NREG*W-1:0] POLYS = {POLY_B, POLY_A};

    logic          wrap;
    logic [W-1:0]  reg_state [NREG];
    logic [W-1:0]  sel_taps;

    rcg_period_fsm #(
        .LEN   (PERIOD),
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk   (clk),
        .rst   (rst),
        .adv   (chip_en),
        .idx   (chip_idx),
        .wrap  (wrap),
        .epoch (epoch)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        rcg_lfsr #(
            .W    (W),
            .POLY (POLYS[g*W +: W]),
            .INIT (SEED_AB)
        ) lfsr_i (
            .clk    (clk),
            .rst    (rst),
            .adv    (chip_en),
            .reload (wrap),
            .state  (reg_state[g])
        );
    end

    always_comb begin
        sel_taps = reg_state[1] & phase_sel;
        chip     = reg_state[0][W-1] ^ (^sel_taps);
    end
endmodule

// File: rtl/rcg_checker.sv
module rcg_checker #(
    parameter int unsigned PERIOD = 2046,
    parameter int unsigned CNT_W  = 11,
    parameter int unsigned W      = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             chip_en,
    input logic [W-1:0]     phase_sel,
    input logic             chip,
    input logic [CNT_W-1:0] chip_idx,
    input logic             epoch
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    // R1: reset clears the index on the next edge
    p_reset_idx_r1: assert property (@(posedge clk) rst |=> chip_idx == '0);

    // R4: single step per enable below the last chip
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (chip_en && chip_idx != LAST) |=> chip_idx == $past(chip_idx) + 1'b1);

    // R4: index range
    p_range_r4: assert property (@(posedge clk) disable iff (rst)
        chip_idx <= LAST);

    // R5: idle hold of index and chip
    p_hold_idx_r5: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> $stable(chip_idx));
    p_hold_chip_r5: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> ($stable(chip) || !$stable(phase_sel)));

    // R6: wrap to zero after the last chip
    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (chip_en && chip_idx == LAST) |=> chip_idx == '0);

    // R7: epoch only on the enabled last chip, and always there
    p_epoch_only_r7: assert property (@(posedge clk) disable iff (rst)
        epoch |-> (chip_en && chip_idx == LAST));
    p_epoch_due_r7: assert property (@(posedge clk) disable iff (rst)
        (chip_en && chip_idx == LAST) |-> epoch);
endmodule

bind trunc_gold_gen rcg_checker #(
    .PERIOD (PERIOD),
    .CNT_W  (CNT_W),
    .W      (W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .chip_en   (chip_en),
    .phase_sel (phase_sel),
    .chip      (chip),
    .chip_idx  (chip_idx),
    .epoch     (epoch)
);

// File: tb/trunc_gold_gen_tb_top.sv
`timescale 1ns/1ps
module trunc_gold_gen_tb_top;
    localparam int CLK_PERIOD = 98;
    localparam int LEN        = 2046;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_en = 1'b0;
    logic [10:0] phase_sel = '0;
    logic        chip;
    logic [10:0] chip_idx;
    logic        epoch;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit m1 [11];
    bit m2 [11];
    int m_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    trunc_gold_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .chip_en   (chip_en),
        .phase_sel (phase_sel),
        .chip      (chip),
        .chip_idx  (chip_idx),
        .epoch     (epoch)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // stage s (1..11) held at m[s-1]; even stages start at one
    function automatic void mdl_seed();
        for (int i = 0; i < 11; i++) begin
            m1[i] = (i % 2 == 1);
            m2[i] = (i % 2 == 1);
        end
        m_idx = 0;
    endfunction

    function automatic void mdl_step();
        bit f1, f2;
        if (m_idx == LEN - 1) begin
            mdl_seed();
            return;
        end
        f1 = m1[0] ^ m1[6] ^ m1[7] ^ m1[8] ^ m1[9] ^ m1[10];
        f2 = m2[0] ^ m2[1] ^ m2[2] ^ m2[3] ^ m2[4] ^ m2[7] ^ m2[8] ^ m2[10];
        for (int i = 10; i > 0; i--) begin
            m1[i] = m1[i-1];
            m2[i] = m2[i-1];
        end
        m1[0] = f1;
        m2[0] = f2;
        m_idx++;
    endfunction

    function automatic bit mdl_chip();
        bit c;
        c = m1[10];
        for (int i = 0; i < 11; i++) c ^= (phase_sel[i] & m2[i]);
        return c;
    endfunction

    // one cycle: drive, sample before the rising edge, advance model
    task automatic cyc(input bit en, input string tag);
        string ctag;
        bit    exp_ep;
        @(negedge clk);
        chip_en = en;
        #1;
        exp_ep = en && (m_idx == LEN - 1);
        if (tag != "") ctag = tag;
        else if (!en) ctag = "R5";
        else if (phase_sel == 0) ctag = "R2";
        else ctag = "R3";
        chk(chip == mdl_chip(), ctag, chip, mdl_chip());
        chk(int'(chip_idx) == m_idx, (tag != "") ? tag : (m_idx == 0 ? "R6" : "R4"),
            chip_idx, m_idx);
        chk(epoch == exp_ep, "R7", epoch, exp_ep);
        if (en) mdl_step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        chip_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mdl_seed();
        cyc(1'b0, "R1");
    endtask

    // n chips, each followed by four idle cycles (chip rate = clock / 5)
    task automatic run_chips(input int n);
        for (int k = 0; k < n; k++) begin
            cyc(1'b1, "");
            repeat (4) cyc(1'b0, "");
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        bit first_chip;
        // R1 and R2: pure first-register sequence across a wrap
        phase_sel = 11'h000;
        do_reset();
        run_chips(LEN + 12);
        // R3 and R6: two-stage selection across a wrap
        phase_sel = 11'h005;
        do_reset();
        first_chip = chip;
        run_chips(LEN);
        #1;
        chk(chip == first_chip && chip_idx == 0, "R6", chip, first_chip);
        run_chips(20);
        // R3: mask change is seen combinationally during idle
        phase_sel = 11'h400;
        cyc(1'b0, "R3");
        phase_sel = 11'h2A1;
        cyc(1'b0, "R3");
        // back-to-back strobes
        for (int k = 0; k < 300; k++) cyc(1'b1, "");
        // R8: reset mid-period
        do_reset();
        chk(chip_idx == 0, "R8", chip_idx, 0);
        chk(chip == mdl_chip(), "R8", chip, mdl_chip());
        run_chips(10);
        done = 1;
        summary();
        $finish;
    end
endmodule